// File: doc/BRIEF.md
# DMA Interrupt Aggregation and Channel Enable Registers

This block is the interrupt and channel-enable register file of a multi-channel DMA controller. Each channel engine raises single-cycle pulses for five kinds of event: transfer done, block done, source transaction done, destination transaction done, and error. For every kind, the block keeps a latched raw vector with one bit per channel, a software mask, and a status view that is the raw vector masked. It also keeps a write-only acknowledge port that drops raw bits. A summary register folds each kind into one bit. A global enable gates the single interrupt output.

Software reaches the block through a plain single-cycle register port. A write is a strobe with an address and 16 data bits. A read is combinational from the address while the strobe is low. The mask registers and the channel-enable register take a per-channel write-enable byte, so one channel's bit can change without a read-modify-write. A channel's enable bit also drops by itself when that channel reports transfer done. The block has no state machine: all behaviour is per-cycle register updates plus combinational read and interrupt logic.

Top module: `dmairq_regs`

## Requirements
- R1: After reset, every raw, mask, channel-enable and global-enable bit is 0, `irq_o` is 0, and every address reads 0.
- R2: A 1 on bit c of an event input sets raw bit c of that kind on the next clock edge, whatever the mask holds. Kind index order is: 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error.
- R3: The status register of kind k reads raw[k] AND mask[k]. Bit k of the summary register (address 20) is the OR of status register k.
- R4: Writing address 15+k clears each raw[k] bit whose data bit [7:0] is 1 and leaves the other bits unchanged. An event on the same channel in the same cycle wins, so the bit stays 1. Raw bits change only through events and these writes.
- R5: A write to mask address 5+k uses bits [7:0] as values and bits [15:8] as per-channel write enables. Only channels whose enable bit is 1 change. A 1 in the mask enables that channel.
- R6: A write to the channel-enable register (address 22) uses the same value/enable split as R5.
- R7: A transfer-done pulse on channel c clears channel-enable bit c on the next edge. This takes priority over a same-cycle write that sets that bit.
- R8: Bit 0 of the configuration register (address 21) is the global enable. `irq_o` equals global enable AND the OR of all status bits, and it follows register state in the same cycle.
- R9: The address map is: raw 0..4, mask 5..9, status 10..14, acknowledge 15..19, summary 20, configuration 21, channel enable 22. Acknowledge addresses and unmapped addresses read 0. Writes to raw, status, summary and unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | REG_W | Write data: values in [7:0], write enables in [15:8] |
| reg_rdata_o | output | REG_W | Combinational read data for `reg_addr_i` |
| ev_xfer_i | input | NCH | Transfer-done pulses, one per channel |
| ev_block_i | input | NCH | Block-done pulses |
| ev_srct_i | input | NCH | Source transaction-done pulses |
| ev_dstt_i | input | NCH | Destination transaction-done pulses |
| ev_err_i | input | NCH | Error pulses |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach from the ports are collisions inside a single cycle. One is an event pulse landing on the same channel and edge as an acknowledge write. The other is a transfer-done pulse coinciding with a channel-enable write that sets the same bit. Directed steps drive the event vector and the write strobe together in one cycle and then read the register back. The seeded random phase mixes sparse event vectors with random writes across the whole address space, so both collisions and ignored writes also occur with many other bit patterns.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    // number of interrupt kinds; index order is fixed by the summary register
    localparam int NCLS   = 5;
    // register map bases (word addresses)
    localparam int A_RAW  = 0;
    localparam int A_MSK  = A_RAW + NCLS;
    localparam int A_STS  = A_MSK + NCLS;
    localparam int A_CLR  = A_STS + NCLS;
    localparam int A_CMB  = A_CLR + NCLS;
    localparam int A_CFG  = A_CMB + 1;
    localparam int A_CHEN = A_CFG + 1;
    // upper byte of write data carries per-channel write enables
    localparam int WE_LSB = 8;
endpackage

// File: rtl/dmairq_class.sv
module dmairq_class
    import dmairq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   evt_i,
    input  logic             clr_wr_i,
    input  logic             msk_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [NCH-1:0]   raw_o,
    output logic [NCH-1:0]   msk_o,
    output logic [NCH-1:0]   sts_o
);
    logic [NCH-1:0] wval;
    logic [NCH-1:0] wen;
    logic [NCH-1:0] ack;

    assign wval = wdata_i[NCH-1:0];
    assign wen  = wdata_i[WE_LSB +: NCH];
    assign ack  = clr_wr_i ? wval : '0;

    // raw latch: event set dominates acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_o <= '0;
        end else begin
            raw_o <= (raw_o & ~ack) | evt_i;
        end
    end

    // mask with per-channel write enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_o <= '0;
        end else if (msk_wr_i) begin
            msk_o <= (msk_o & ~wen) | (wval & wen);
        end
    end

    assign sts_o = raw_o & msk_o;
endmodule

// File: rtl/dmairq_chen.sv
module dmairq_chen
    import dmairq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [NCH-1:0]   done_i,
    output logic [NCH-1:0]   chen_o
);
    logic [NCH-1:0] wval;
    logic [NCH-1:0] wen;
    logic [NCH-1:0] merged;

    assign wval = wdata_i[NCH-1:0];
    assign wen  = wdata_i[WE_LSB +: NCH];

    always_comb begin
        merged = chen_o;
        if (wr_i) begin
            merged = (chen_o & ~wen) | (wval & wen);
        end
    end

    // transfer-done clears the enable after any software update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chen_o <= '0;
        end else begin
            chen_o <= merged & ~done_i;
        end
    end
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
    import dmairq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NCLS-1:0][NCH-1:0]   raw_i,
    input  logic [NCLS-1:0][NCH-1:0]   msk_i,
    input  logic [NCLS-1:0][NCH-1:0]   sts_i,
    input  logic [NCLS-1:0]            cmb_i,
    input  logic                       gen_i,
    input  logic [NCH-1:0]             chen_i,
    output logic [REG_W-1:0]           rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NCLS; k++) begin
            if (addr_i == ADDR_W'(A_RAW + k)) rdata_o[NCH-1:0] = raw_i[k];
            if (addr_i == ADDR_W'(A_MSK + k)) rdata_o[NCH-1:0] = msk_i[k];
            if (addr_i == ADDR_W'(A_STS + k)) rdata_o[NCH-1:0] = sts_i[k];
        end
        if (addr_i == ADDR_W'(A_CMB))  rdata_o[NCLS-1:0] = cmb_i;
        if (addr_i == ADDR_W'(A_CFG))  rdata_o[0]        = gen_i;
        if (addr_i == ADDR_W'(A_CHEN)) rdata_o[NCH-1:0]  = chen_i;
    end
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
    import dmairq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [NCH-1:0]    ev_xfer_i,
    input  logic [NCH-1:0]    ev_block_i,
    input  logic [NCH-1:0]    ev_srct_i,
    input  logic [NCH-1:0]    ev_dstt_i,
    input  logic [NCH-1:0]    ev_err_i,
    output logic              irq_o
);
    logic [NCLS-1:0][NCH-1:0] evt;
    logic [NCLS-1:0][NCH-1:0] raw_q;
    logic [NCLS-1:0][NCH-1:0] msk_q;
    logic [NCLS-1:0][NCH-1:0] sts;
    logic [NCLS-1:0]          cmb;
    logic [NCLS-1:0]          clr_wr;
    logic [NCLS-1:0]          msk_wr;
    logic                     cfg_wr;
    logic                     chen_wr;
    logic                     gen_q;
    logic [NCH-1:0]           chen_q;

    assign evt = {ev_err_i, ev_dstt_i, ev_srct_i, ev_block_i, ev_xfer_i};

    assign cfg_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(A_CFG));
    assign chen_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_CHEN));

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        assign clr_wr[k] = reg_wr_i && (reg_addr_i == ADDR_W'(A_CLR + k));
        assign msk_wr[k] = reg_wr_i && (reg_addr_i == ADDR_W'(A_MSK + k));
        assign cmb[k]    = |sts[k];

        dmairq_class #(.NCH(NCH), .REG_W(REG_W)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt[k]),
            .clr_wr_i (clr_wr[k]),
            .msk_wr_i (msk_wr[k]),
            .wdata_i  (reg_wdata_i),
            .raw_o    (raw_q[k]),
            .msk_o    (msk_q[k]),
            .sts_o    (sts[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= 1'b0;
        end else if (cfg_wr) begin
            gen_q <= reg_wdata_i[0];
        end
    end

    dmairq_chen #(.NCH(NCH), .REG_W(REG_W)) u_chen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (chen_wr),
        .wdata_i (reg_wdata_i),
        .done_i  (ev_xfer_i),
        .chen_o  (chen_q)
    );

    dmairq_rdmux #(.NCH(NCH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_rd (
        .addr_i  (reg_addr_i),
        .raw_i   (raw_q),
        .msk_i   (msk_q),
        .sts_i   (sts),
        .cmb_i   (cmb),
        .gen_i   (gen_q),
        .chen_i  (chen_q),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o = gen_q && (|cmb);
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
    import dmairq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_i,
    input logic [ADDR_W-1:0]   reg_addr_i,
    input logic [REG_W-1:0]    reg_wdata_i,
    input logic [NCLS*NCH-1:0] evt_all,
    input logic [NCLS*NCH-1:0] raw_all,
    input logic [NCLS*NCH-1:0] msk_all,
    input logic [NCH-1:0]      ev_xfer_i,
    input logic [NCH-1:0]      chen_q,
    input logic                gen_q,
    input logic                irq_o
);
    logic mask_hit;
    assign mask_hit = reg_wr_i && (reg_addr_i >= ADDR_W'(A_MSK))
                      && (reg_addr_i < ADDR_W'(A_MSK + NCLS));

    AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all != '0) |=> ((raw_all & $past(evt_all)) == $past(evt_all))); // R2

    AST_RAW_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && evt_all == '0) |=> $stable(raw_all)); // R4

    AST_MASK_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_hit && reg_wdata_i[WE_LSB +: NCH] == '0) |=> $stable(msk_all)); // R5

    AST_CHEN_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(A_CHEN) && reg_wdata_i[WE_LSB +: NCH] == '0
         && ev_xfer_i == '0) |=> $stable(chen_q)); // R6

    AST_CHEN_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_xfer_i != '0) |=> ((chen_q & $past(ev_xfer_i)) == '0)); // R7

    AST_IRQ_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q |-> !irq_o); // R8
endmodule

bind dmairq_regs dmairq_chk #(.NCH(NCH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .evt_all     (evt),
    .raw_all     (raw_q),
    .msk_all     (msk_q),
    .ev_xfer_i   (ev_xfer_i),
    .chen_q      (chen_q),
    .gen_q       (gen_q),
    .irq_o       (irq_o)
);

// File: tb/sim_dmairq_regs.sv
`timescale 1ns/1ps
module sim_dmairq_regs;
    localparam int NCH = 8;
    localparam int NC  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [NCH-1:0] ev [NC];
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_raw [NC];
    logic [7:0] m_msk [NC];
    logic [7:0] m_chen;
    logic       m_gen;

    always #2 clk = ~clk;

    dmairq_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ev_xfer_i(ev[0]), .ev_block_i(ev[1]), .ev_srct_i(ev[2]),
        .ev_dstt_i(ev[3]), .ev_err_i(ev[4]), .irq_o(irq)
    );

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        logic [15:0] r = '0;
        if (a < 5)        r[7:0] = m_raw[a];
        else if (a < 10)  r[7:0] = m_msk[a-5];
        else if (a < 15)  r[7:0] = m_raw[a-10] & m_msk[a-10];
        else if (a < 20)  r = '0;
        else if (a == 20) begin
            for (int k = 0; k < NC; k++) r[k] = |(m_raw[k] & m_msk[k]);
        end
        else if (a == 21) r[0] = m_gen;
        else if (a == 22) r[7:0] = m_chen;
        return r;
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int k = 0; k < NC; k++) any = any | (|(m_raw[k] & m_msk[k]));
        return m_gen & any;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock with optional write and event vectors; model updated alongside
    task automatic step(input logic wr, input logic [4:0] a, input logic [15:0] d,
                        input logic [39:0] evv);
        logic [7:0] e [NC];
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            e[k] = evv[k*8 +: 8];
            ev[k] = e[k];
        end
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        for (int k = 0; k < NC; k++) begin
            logic [7:0] ack;
            ack = (wr && a == 5'(15 + k)) ? d[7:0] : 8'h00;
            m_raw[k] = (m_raw[k] & ~ack) | e[k];
            if (wr && a == 5'(5 + k)) m_msk[k] = (m_msk[k] & ~d[15:8]) | (d[7:0] & d[15:8]);
        end
        if (wr && a == 5'd22) m_chen = (m_chen & ~d[15:8]) | (d[7:0] & d[15:8]);
        m_chen = m_chen & ~e[0];
        if (wr && a == 5'd21) m_gen = d[0];
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        for (int k = 0; k < NC; k++) ev[k] = '0;
        chk("R8 irq", {15'd0, irq}, {15'd0, exp_irq()});
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        chk(req, reg_rdata, exp_read(a));
    endtask

    initial begin
        #(4.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NC; k++) begin
            ev[k] = '0; m_raw[k] = '0; m_msk[k] = '0;
        end
        m_chen = '0; m_gen = 1'b0;
        void'($urandom(32'h5eed1234));
        #9;
        // R1: reset values
        chk("R1 irq", {15'd0, irq}, 16'd0);
        for (int a = 0; a < 32; a++) begin
            reg_addr = 5'(a); #1;
            chk("R1 read", reg_rdata, 16'd0);
        end
        @(negedge clk); rst_n = 1'b1;

        step(1, 5'd21, 16'h0001, '0);
        rd(5'd21, "R8 cfg");
        // R2: unmasked event latched
        step(0, 5'd0, 16'h0, 40'h00_00_00_08_00);
        rd(5'd1, "R2 raw");
        rd(5'd11, "R3 sts");
        // R5: masked enable of ch3 only
        step(1, 5'd6, 16'h0808, '0);
        rd(5'd6, "R5 mask");
        rd(5'd20, "R3 summary");
        step(1, 5'd6, 16'h00ff, '0);
        rd(5'd6, "R5 no enable");
        // R4: acknowledge and collision
        step(1, 5'd16, 16'h0008, '0);
        rd(5'd1, "R4 ack");
        step(1, 5'd16, 16'h0008, 40'h00_00_00_08_00);
        rd(5'd1, "R4 event wins");
        // R8: global disable
        step(1, 5'd21, 16'h0000, '0);
        // R6 / R7
        step(1, 5'd22, 16'hffff, '0);
        rd(5'd22, "R6 chen all");
        step(1, 5'd22, 16'h0100, '0);
        rd(5'd22, "R6 chen one");
        step(1, 5'd22, 16'h0101, 40'h00_00_00_00_03);
        rd(5'd22, "R7 autoclear");
        // R9: read-only and unmapped writes ignored
        step(1, 5'd1, 16'hffff, '0);
        step(1, 5'd11, 16'hffff, '0);
        step(1, 5'd20, 16'hffff, '0);
        step(1, 5'd27, 16'hffff, '0);
        rd(5'd1, "R9 raw ro");
        rd(5'd16, "R9 ack reads 0");
        rd(5'd27, "R9 unmapped");

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [39:0] evv = '0;
            logic        wr;
            logic [4:0]  a;
            for (int k = 0; k < NC; k++)
                if ($urandom % 5 == 0) evv[k*8 +: 8] = 8'($urandom) & 8'($urandom);
            wr = ($urandom % 2) == 1;
            a  = ($urandom % 3 == 0) ? 5'(15 + $urandom % 5) : 5'($urandom);
            step(wr, a, 16'($urandom), evv);
            if (i % 10 == 9)
                for (int r = 0; r < 32; r++) rd(5'(r), "R3 random readback");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule